// File: doc/BRIEF.md
# Mirrored Memory Region Decoder

This block sits in front of a CPU memory system and turns each 32-bit bus address into a region choice and an offset within that region. The upper 16 address bits act as a 64 KB page number. Main RAM and the boot ROM are each reachable through three address segments: a plain one, a cached one and an uncached one. All three segments resolve to the same storage. One page opens the peripheral register window. Another page holds a bus-interface control word. Every page that none of these claim is unmapped.

The decode is purely combinational. The only stored state is a RAM write-protect flag. Firmware sets or clears it by writing certain values to one address in the control page. While the flag is set, 32-bit stores to the very first RAM page are refused. Stores of the other sizes, and stores through the mirror segments, still go through.

The block drives a RAM write enable and tells the read path when to return zero. The storage arrays and the peripheral handlers sit outside this block.

Top module: `mirror_region_decoder`

## Requirements
- R1: A page whose top three bits are 000, 100 or 101 and whose low 13 bits are below 0x0080 decodes to RAM (region code 1). The offset is address bits [20:0].
- R2: A page in the same three segments whose low 13 bits lie in 0x1FC0..0x1FC7 decodes to ROM (region code 2). The offset is address bits [18:0]. Writes there never raise the RAM write enable.
- R3: Page 0x1F80 decodes to the peripheral window (region code 3) for byte, half-word and word accesses alike. The offset is address bits [15:0].
- R4: Page 0xFFFE decodes to the control page (region code 4). The offset is address bits [15:0]. A read there asserts the read-zero indication.
- R5: The RAM write enable rises only for a write that decodes to RAM, and it does so for any size unless R8 blocks it.
- R6: A word write (size code 2) to address 0xFFFE0130 sets the protect flag when the data is 0x800 or 0x804. It clears the flag when the data is 0x0 or 0x1E988. The change takes effect from the next clock edge.
- R7: The protect flag keeps its value for any other data value at that address, for a byte or half-word (size 0 or 1) write there, and for a write to any other address in page 0xFFFE.
- R8: While the flag is set, a word write to page 0x0000 gives no RAM write enable. Byte and half-word writes to page 0x0000, word writes to other RAM pages, and word writes to the mirrored page 0x8000 are still enabled.
- R9: Any other page decodes to unmapped (region code 0) with a zero offset. A read there asserts the read-zero indication, and a write there gives no write enable.
- R10: Reset clears the protect flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the protect flag |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 32 | Bus address |
| size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| region | output | 3 | 0 unmapped, 1 RAM, 2 ROM, 3 peripheral, 4 control |
| offset | output | 21 | Offset within the selected region |
| ram_we | output | 1 | RAM write enable |
| rd_zero | output | 1 | The read must return zero |

## Verification
Random addresses are drawn from a pool of pages that sit just inside and just outside every range: the first and last RAM page of each segment, page 0x0080, the ROM edges in each mirror, the peripheral and control pages, and wholly random pages. These separate a range comparison that is off by one from a correct one, and a missing mirror from a present one. Directed write sequences to the control address use every set and clear value, a neutral value, non-word sizes and a neighbouring address. Each sequence is followed by probe writes to page 0x0000, its mirror at 0x8000 and page 0x0001. Together these tell a flag that moves wrongly apart from a block that is applied too broadly.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

  typedef enum logic [2:0] {
    RGN_NONE = 3'd0,
    RGN_RAM  = 3'd1,
    RGN_BIOS = 3'd2,
    RGN_IO   = 3'd3,
    RGN_CTRL = 3'd4
  } region_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // Data values that switch the RAM write-protect flag on.
  function automatic logic is_protect_on(input logic [31:0] d);
    return (d == 32'h0000_0800) || (d == 32'h0000_0804);
  endfunction

  // Data values that switch the flag off.
  function automatic logic is_protect_off(input logic [31:0] d);
    return (d == 32'h0000_0000) || (d == 32'h0001_E988);
  endfunction

  // Top three page bits of each mirror segment: plain, cached, uncached.
  function automatic logic [2:0] seg_prefix(input int idx);
    case (idx)
      0:       return 3'b000;
      1:       return 3'b100;
      default: return 3'b101;
    endcase
  endfunction

endpackage

// File: rtl/mrd_page_classifier.sv
module mrd_page_classifier
  import mrd_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          PAGE_W     = 16,
  parameter int          OFF_W      = 21,
  parameter int          RAM_OFF_W  = 21,
  parameter int          BIOS_OFF_W = 19,
  parameter int          IO_OFF_W   = 16,
  parameter int          NSEG       = 3,
  parameter int          RAM_PAGES  = 128,
  parameter int          BIOS_BASE  = 'h1FC0,
  parameter int          BIOS_PAGES = 8,
  parameter logic [15:0] IO_PAGE    = 16'h1F80,
  parameter logic [15:0] CTRL_PAGE  = 16'hFFFE
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [OFF_W-1:0]  offset
);

  localparam int SEG_W = 3;
  localparam int LOW_W = PAGE_W - SEG_W;
  localparam logic [LOW_W-1:0] RAM_LIM  = LOW_W'(RAM_PAGES);
  localparam logic [LOW_W-1:0] BIOS_LO  = LOW_W'(BIOS_BASE);
  localparam logic [LOW_W-1:0] BIOS_HI  = LOW_W'(BIOS_BASE + BIOS_PAGES);

  logic [PAGE_W-1:0] page;
  logic [SEG_W-1:0]  pre;
  logic [LOW_W-1:0]  low;
  logic [NSEG-1:0]   seg_match;
  logic              in_mirror;
  logic              ram_hit;
  logic              bios_hit;
  logic              io_hit;
  logic              ctrl_hit;

  assign page = addr[ADDR_W-1 -: PAGE_W];
  assign pre  = page[PAGE_W-1 -: SEG_W];
  assign low  = page[LOW_W-1:0];

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    assign seg_match[g] = (pre == seg_prefix(g));
  end

  assign in_mirror = |seg_match;
  assign ram_hit   = in_mirror && (low < RAM_LIM);
  assign bios_hit  = in_mirror && (low >= BIOS_LO) && (low < BIOS_HI);
  assign io_hit    = (page == PAGE_W'(IO_PAGE));
  assign ctrl_hit  = (page == PAGE_W'(CTRL_PAGE));

  always_comb begin
    region = RGN_NONE;
    offset = '0;
    if (ram_hit) begin
      region = RGN_RAM;
      offset = OFF_W'(addr[RAM_OFF_W-1:0]);
    end else if (bios_hit) begin
      region = RGN_BIOS;
      offset = OFF_W'(addr[BIOS_OFF_W-1:0]);
    end else if (io_hit) begin
      region = RGN_IO;
      offset = OFF_W'(addr[IO_OFF_W-1:0]);
    end else if (ctrl_hit) begin
      region = RGN_CTRL;
      offset = OFF_W'(addr[IO_OFF_W-1:0]);
    end
  end

endmodule

// File: rtl/mrd_protect_latch.sv
module mrd_protect_latch
  import mrd_pkg::*;
#(
  parameter int               ADDR_W    = 32,
  parameter int               DATA_W    = 32,
  parameter logic [31:0]      CTRL_ADDR = 32'hFFFE_0130
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              wp_q,
  output logic              set_evt,
  output logic              clr_evt
);

  logic ctrl_word_wr;

  assign ctrl_word_wr = wr && (size == SZ_WORD) && (addr == ADDR_W'(CTRL_ADDR));
  assign set_evt      = ctrl_word_wr && is_protect_on(32'(wdata));
  assign clr_evt      = ctrl_word_wr && is_protect_off(32'(wdata));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wp_q <= 1'b0;
    else if (set_evt) wp_q <= 1'b1;
    else if (clr_evt) wp_q <= 1'b0;
  end

endmodule

// File: rtl/mirror_region_decoder.sv
module mirror_region_decoder
  import mrd_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          DATA_W     = 32,
  parameter int          PAGE_W     = 16,
  parameter int          RAM_OFF_W  = 21,
  parameter int          BIOS_OFF_W = 19,
  parameter int          IO_OFF_W   = 16,
  parameter int          RAM_PAGES  = 128,
  parameter int          BIOS_BASE  = 'h1FC0,
  parameter int          BIOS_PAGES = 8,
  parameter logic [15:0] IO_PAGE    = 16'h1F80,
  parameter logic [15:0] CTRL_PAGE  = 16'hFFFE,
  parameter logic [31:0] CTRL_ADDR  = 32'hFFFE_0130,
  parameter logic [15:0] PROT_PAGE  = 16'h0000,
  parameter int          OFF_W      = RAM_OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [2:0]        region,
  output logic [OFF_W-1:0]  offset,
  output logic              ram_we,
  output logic              rd_zero
);

  region_e rgn;
  logic    wp_q;
  logic    wp_set_evt;
  logic    wp_clr_evt;
  logic    prot_blk;
  logic    ram_wr;

  mrd_page_classifier #(
    .ADDR_W    (ADDR_W),
    .PAGE_W    (PAGE_W),
    .OFF_W     (OFF_W),
    .RAM_OFF_W (RAM_OFF_W),
    .BIOS_OFF_W(BIOS_OFF_W),
    .IO_OFF_W  (IO_OFF_W),
    .NSEG      (3),
    .RAM_PAGES (RAM_PAGES),
    .BIOS_BASE (BIOS_BASE),
    .BIOS_PAGES(BIOS_PAGES),
    .IO_PAGE   (IO_PAGE),
    .CTRL_PAGE (CTRL_PAGE)
  ) i_cls (
    .addr  (addr),
    .region(rgn),
    .offset(offset)
  );

  mrd_protect_latch #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CTRL_ADDR(CTRL_ADDR)
  ) i_wp (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (wr),
    .size   (size),
    .addr   (addr),
    .wdata  (wdata),
    .wp_q   (wp_q),
    .set_evt(wp_set_evt),
    .clr_evt(wp_clr_evt)
  );

  // A write that targets RAM; the protect rule may still cancel it.
  assign ram_wr   = wr && (rgn == RGN_RAM);
  assign prot_blk = wp_q && (size == SZ_WORD) &&
                    (addr[ADDR_W-1 -: PAGE_W] == PAGE_W'(PROT_PAGE));
  assign ram_we   = ram_wr && !prot_blk;
  assign rd_zero  = rd && ((rgn == RGN_NONE) || (rgn == RGN_CTRL));
  assign region   = rgn;

endmodule

// File: rtl/mrd_checker.sv
module mrd_checker
  import mrd_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] addr,
  input logic [1:0]  size,
  input logic        wr,
  input logic [2:0]  region,
  input logic        ram_we,
  input logic        rd_zero,
  input logic        wp_q,
  input logic        wp_set_evt,
  input logic        wp_clr_evt
);

  p_we_in_ram_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (wr && region == 3'd1));

  p_bios_no_we_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (region == 3'd2) |-> !ram_we);

  p_wp_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wp_set_evt |=> wp_q);

  p_wp_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wp_clr_evt |=> !wp_q);

  p_wp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_set_evt && !wp_clr_evt) |=> $stable(wp_q));

  p_word_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_q && wr && size == SZ_WORD && addr[31:16] == 16'h0000) |-> !ram_we);

  p_zero_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_zero |-> (region == 3'd0 || region == 3'd4));

endmodule

bind mirror_region_decoder mrd_checker i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr      (addr),
  .size      (size),
  .wr        (wr),
  .region    (region),
  .ram_we    (ram_we),
  .rd_zero   (rd_zero),
  .wp_q      (wp_q),
  .wp_set_evt(wp_set_evt),
  .wp_clr_evt(wp_clr_evt)
);

// File: tb/test_mirror_region_decoder.sv
module test_mirror_region_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic [1:0]  size = '0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [2:0]  region;
  logic [20:0] offset;
  logic        ram_we;
  logic        rd_zero;

  int  checks = 0;
  int  fails  = 0;
  bit  m_wp   = 1'b0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;

  mirror_region_decoder i_mirror_region_decoder (
    .clk(clk), .rst_n(rst_n), .addr(addr), .size(size), .rd(rd), .wr(wr),
    .wdata(wdata), .region(region), .offset(offset), .ram_we(ram_we),
    .rd_zero(rd_zero)
  );

  function automatic int exp_region(input logic [31:0] a);
    int pg  = int'(a[31:16]);
    int hi  = pg / 'h2000;
    int lo  = pg % 'h2000;
    bit mir = (hi == 0) || (hi == 4) || (hi == 5);
    if (mir && lo <= 'h7F) return 1;
    if (mir && lo >= 'h1FC0 && lo <= 'h1FC7) return 2;
    if (pg == 'h1F80) return 3;
    if (pg == 'hFFFE) return 4;
    return 0;
  endfunction

  function automatic logic [31:0] exp_offset(input logic [31:0] a, input int r);
    case (r)
      1:       return a % 32'h0020_0000;
      2:       return a % 32'h0008_0000;
      3, 4:    return a % 32'h0001_0000;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string req_of(input int r);
    case (r)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic [1:0] sz,
                        input bit r, input bit w, input logic [31:0] d,
                        input string we_req);
    int  er;
    bit  blk;
    bit  ewe;
    @(negedge clk);
    addr = a; size = sz; rd = r; wr = w; wdata = d;
    #2;
    er  = exp_region(a);
    blk = m_wp && (sz == 2'd2) && (a[31:16] == 16'h0000);
    ewe = w && (er == 1) && !blk;
    chk(req_of(er), "region", 32'(region), 32'(er));
    chk(req_of(er), "offset", 32'(offset), exp_offset(a, er));
    chk(req_of(er), "rd_zero", 32'(rd_zero), 32'(r && (er == 0 || er == 4)));
    chk(blk ? "R8" : we_req, "ram_we", 32'(ram_we), 32'(ewe));
    if (w && sz == 2'd2 && a == 32'hFFFE_0130) begin
      if (d == 32'h800 || d == 32'h804) m_wp = 1'b1;
      else if (d == 32'h0 || d == 32'h1E988) m_wp = 1'b0;
    end
  endtask

  // Probe the flag through ram_we with a word write to page 0.
  task automatic probe(input string req);
    access(32'h0000_0100, 2'd2, 1'b0, 1'b1, 32'h1, req);
  endtask

  function automatic logic [31:0] pick_addr();
    logic [15:0] pg;
    case ($urandom % 12)
      0:  pg = 16'h0000;
      1:  pg = 16'h007F;
      2:  pg = 16'h8012;
      3:  pg = 16'hA07F;
      4:  pg = 16'h0080;
      5:  pg = 16'h1FC3;
      6:  pg = 16'h9FC7;
      7:  pg = 16'hBFC0;
      8:  pg = 16'h1F80;
      9:  pg = 16'hFFFE;
      10: pg = 16'h1FC8;
      default: pg = 16'($urandom);
    endcase
    return {pg, 16'($urandom)};
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R10: flag is clear after reset
    probe("R10");

    // R6 set, R8 blocking and its limits
    access(32'hFFFE_0130, 2'd2, 1'b0, 1'b1, 32'h800, "R6");
    probe("R6");
    access(32'h0000_0004, 2'd0, 1'b0, 1'b1, 32'h5, "R8");
    access(32'h0000_0006, 2'd1, 1'b0, 1'b1, 32'h5, "R8");
    access(32'h8000_0000, 2'd2, 1'b0, 1'b1, 32'h5, "R8");
    access(32'h0001_0000, 2'd2, 1'b0, 1'b1, 32'h5, "R8");

    // R7: non-qualifying writes leave the flag set
    access(32'hFFFE_0130, 2'd2, 1'b0, 1'b1, 32'h12, "R7");
    probe("R7");
    access(32'hFFFE_0130, 2'd1, 1'b0, 1'b1, 32'h0, "R7");
    probe("R7");
    access(32'hFFFE_0134, 2'd2, 1'b0, 1'b1, 32'h0, "R7");
    probe("R7");

    // R6: both clear values and the second set value
    access(32'hFFFE_0130, 2'd2, 1'b0, 1'b1, 32'h1E988, "R6");
    probe("R6");
    access(32'hFFFE_0130, 2'd2, 1'b0, 1'b1, 32'h804, "R6");
    probe("R6");
    access(32'hFFFE_0130, 2'd2, 1'b0, 1'b1, 32'h0, "R6");
    probe("R6");

    // R10: reset while set
    access(32'hFFFE_0130, 2'd2, 1'b0, 1'b1, 32'h800, "R6");
    @(negedge clk);
    wr = 1'b0;
    rst_n = 1'b0;
    m_wp = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    probe("R10");

    // R2: write to ROM, R3 all sizes, R4 control read, R9 unmapped
    access(32'hBFC1_2345, 2'd2, 1'b0, 1'b1, 32'h7, "R2");
    access(32'h1F80_1040, 2'd0, 1'b1, 1'b0, 32'h0, "R3");
    access(32'h1F80_1044, 2'd1, 1'b0, 1'b1, 32'h3, "R3");
    access(32'h1F80_1100, 2'd2, 1'b1, 1'b0, 32'h0, "R3");
    access(32'hFFFE_0130, 2'd2, 1'b1, 1'b0, 32'h0, "R4");
    access(32'h4000_0000, 2'd2, 1'b1, 1'b1, 32'h9, "R9");

    // Random mix, R1..R9
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a;
      logic [31:0] d;
      bit w;
      a = pick_addr();
      w = ($urandom % 2) == 1;
      case ($urandom % 6)
        0: d = 32'h800;
        1: d = 32'h804;
        2: d = 32'h0;
        3: d = 32'h1E988;
        default: d = $urandom;
      endcase
      if (($urandom % 8) == 0) a = 32'hFFFE_0130;
      access(a, 2'($urandom % 3), !w, w, d, "R5");
    end

    @(negedge clk);
    wr = 1'b0;
    rd = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule